// File: doc/BRIEF.md
# Table-Based DDS Waveform Generator

This block is a direct digital synthesis core for one output channel. A 32-bit phase accumulator steps by a tuning word on each sample-enable pulse. A 12-bit phase index is formed from the top of the accumulator plus a phase offset. That index either addresses a 4096-word sample table or drives arithmetic shape generators for pulse, triangle and sawtooth. Each enabled sample yields one 16-bit unsigned code, where 0 is the most negative level and 0xFFFF the most positive.

A host loads the table through a write port while the channel is disabled. The table holds one period of a sine or of any custom shape. A per-period transform can time-reverse the index, invert the code, or do both. A sync input from a master channel restarts the phase so that several channels keep a fixed phase relation, set by each channel's offset.

The accumulator resolution gives a frequency step of the sample rate divided by 2^32. A new tuning word or offset applies to the very next sample, with no settling time.

Top module: `dds_wavegen`

## Requirements
- R1: After reset `sample_out` is 0x0000 and `sample_vld` is 0.
- R2: While `en` is 1, each `smp_en` cycle adds `tuning_word` to the accumulator (modulo 2^32). The sample uses index = (accumulator[31:20] before the add + `phase_ofs`) mod 4096. Its code appears on `sample_out` with `sample_vld` high for one cycle after the second rising edge following the `smp_en` edge.
- R3: A `sync_pulse` while enabled makes that cycle's sample use accumulator value 0. The accumulator then holds `tuning_word` if `smp_en` was also high, and 0 otherwise.
- R4: Shape code 0 (sine) and code 1 (custom) output the table word at the index.
- R5: A table write (`tbl_we`) is accepted only while `en` is 0. A write while `en` is 1 leaves the table unchanged.
- R6: Shape code 2 (pulse), with index p, rise r, plateau d (`duty`) and fall f, all in 1/4096 of a period:
  - p < r gives p*65535/r (integer division).
  - r ≤ p < r+d gives 65535.
  - r+d ≤ p < r+d+f gives 65535 − (p−r−d)*65535/f.
  - Any other p gives 0.
  - With r = f = 0 this is a square wave that is high for d/4096 of the period.
- R7: Shape code 3 (triangle) is the pulse with r = f = 2048 and d = 0. The `duty`, `rise_frac` and `fall_frac` inputs are ignored.
- R8: Shape code 4 (sawtooth) outputs index*16 + index/256, a ramp from 0x0000 at index 0 to 0xFFFF at index 4095.
- R9: Bit 0 of `xform_sel` (mirror) replaces the index by 4095 − index. Bit 1 (invert) replaces the code v by 65535 − v. The encodings are 0 none, 1 mirror, 2 invert and 3 both.
- R10: While `en` is 0 no sample is produced and the accumulator is held at 0. After re-enable the first sample uses accumulator 0.
- R11: Shape codes 5 to 7 output midscale 0x8000, before any inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable; table writes only when low |
| smp_en | input | 1 | Sample-enable pulse |
| sync_pulse | input | 1 | Phase restart from master channel |
| tuning_word | input | 32 | Phase step per sample |
| phase_ofs | input | 12 | Phase offset, 1/4096 period units |
| duty | input | 12 | Pulse plateau length |
| rise_frac | input | 12 | Pulse rising-edge length |
| fall_frac | input | 12 | Pulse falling-edge length |
| shape_sel | input | 3 | Shape code |
| xform_sel | input | 2 | Transform: bit0 mirror, bit1 invert |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 12 | Table write address |
| tbl_wdata | input | 16 | Table write data |
| sample_out | output | 16 | Output code |
| sample_vld | output | 1 | New sample strobe |

## Verification
A corrupted accumulator shows as a wrong table or ramp code on the first sample after the fault. The error then persists until the next sync, because every later index inherits it. A wrong mirror or pulse boundary shows only at particular indices, so the shapes are swept across all 4096 indices against an arithmetic model. A write that leaks through while the channel runs stays hidden until that address is read, so the bench places the phase exactly on the written entry.

// File: rtl/dds_pkg.sv
// Shared shape codes and transform bit positions for the DDS generator.
// Assumes: shape codes above the last named one are treated as midscale.
package dds_pkg;
    typedef enum logic [2:0] {
        SHP_SINE   = 3'd0,
        SHP_CUSTOM = 3'd1,
        SHP_PULSE  = 3'd2,
        SHP_TRI    = 3'd3,
        SHP_SAW    = 3'd4
    } shape_e;

    localparam int XF_MIRROR_BIT = 0;
    localparam int XF_INVERT_BIT = 1;
endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator plus registered index stage.
// Forms index = top bits of accumulator + offset, optionally mirrored, and
// registers it on each sample enable (this register is the table address).
// Assumes: disabled channel holds accumulator at zero; sync beats step.
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp_en,
    input  logic             sync_pulse,
    input  logic [ACC_W-1:0] tw,
    input  logic [IDX_W-1:0] ofs,
    input  logic             mirror,
    output logic [ACC_W-1:0] acc_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             stg_vld
);
    logic [IDX_W-1:0] base_idx;
    logic [IDX_W-1:0] sum_idx;

    // Index before registering: sync forces zero phase for this sample
    always_comb begin
        base_idx = sync_pulse ? '0 : acc_q[ACC_W-1 -: IDX_W];
        sum_idx  = base_idx + ofs;
    end

    // Accumulator, index register and stage-valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            idx_q   <= '0;
            stg_vld <= 1'b0;
        end else if (!en) begin
            acc_q   <= '0;
            stg_vld <= 1'b0;
        end else begin
            stg_vld <= smp_en;
            if (sync_pulse)
                acc_q <= smp_en ? tw : '0;
            else if (smp_en)
                acc_q <= acc_q + tw;
            if (smp_en)
                idx_q <= mirror ? ~sum_idx : sum_idx;
        end
    end
endmodule

// File: rtl/dds_sample_table.sv
// Sample table: synchronous host write, read from an already registered
// address. Assumes writes are meaningful only while the channel is disabled.
module dds_sample_table #(
    parameter int IDX_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Host write, blocked while the channel runs
    always_ff @(posedge clk) begin
        if (we && !en)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dds_shape_calc.sv
// Combinational shape generator: maps a phase index to an output code for
// table, pulse/trapezoid, triangle and sawtooth shapes.
// Assumes DATA_W - IDX_W <= IDX_W (sawtooth fills low bits from the index).
module dds_shape_calc #(
    parameter int IDX_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        shape,
    input  logic [IDX_W-1:0]  duty,
    input  logic [IDX_W-1:0]  rise,
    input  logic [IDX_W-1:0]  fall,
    input  logic [DATA_W-1:0] tbl_data,
    output logic [DATA_W-1:0] value
);
    import dds_pkg::*;

    localparam int          PRD_W = IDX_W + DATA_W;
    localparam int          EDG_W = IDX_W + 2;
    localparam int          LOW_W = DATA_W - IDX_W;
    localparam [DATA_W-1:0] FULL  = {DATA_W{1'b1}};
    localparam [DATA_W-1:0] MID   = DATA_W'(1) << (DATA_W - 1);
    localparam [IDX_W-1:0]  HALF  = IDX_W'(1) << (IDX_W - 1);

    logic [IDX_W-1:0]  r_eff, d_eff, f_eff;
    logic [EDG_W-1:0]  e_high, e_fall, e_low, p_ext, q_ext;
    logic [PRD_W-1:0]  quo_up, quo_dn;
    logic [DATA_W-1:0] pulse_v, saw_v;

    // Triangle is the pulse with half-period edges and no plateau
    always_comb begin
        if (shape == SHP_TRI) begin
            r_eff = HALF;
            d_eff = '0;
            f_eff = HALF;
        end else begin
            r_eff = rise;
            d_eff = duty;
            f_eff = fall;
        end
    end

    // Pulse/trapezoid: ramp up, plateau, ramp down, low
    always_comb begin
        p_ext  = EDG_W'(idx);
        e_high = EDG_W'(r_eff);
        e_fall = e_high + EDG_W'(d_eff);
        e_low  = e_fall + EDG_W'(f_eff);
        q_ext  = p_ext - e_fall;
        quo_up = (r_eff == '0) ? '0
               : (PRD_W'(idx) * PRD_W'(FULL)) / PRD_W'(r_eff);
        quo_dn = (f_eff == '0) ? '0
               : (PRD_W'(q_ext) * PRD_W'(FULL)) / PRD_W'(f_eff);
        if (p_ext < e_high)
            pulse_v = quo_up[DATA_W-1:0];
        else if (p_ext < e_fall)
            pulse_v = FULL;
        else if (p_ext < e_low)
            pulse_v = FULL - quo_dn[DATA_W-1:0];
        else
            pulse_v = '0;
    end

    // Sawtooth: index in the high bits, repeated into the low bits
    assign saw_v = {idx, idx[IDX_W-1 -: LOW_W]};

    // Shape select
    always_comb begin
        case (shape)
            SHP_SINE, SHP_CUSTOM: value = tbl_data;
            SHP_PULSE, SHP_TRI:   value = pulse_v;
            SHP_SAW:              value = saw_v;
            default:              value = MID;
        endcase
    end
endmodule

// File: rtl/dds_wavegen.sv
// Top of the DDS waveform generator: accumulator and index stage, table,
// shape generator and registered output with optional inversion.
// Latency: sample code appears two edges after the sample-enable edge.
// Assumes the host keeps shape/transform stable across a sample's pipeline.
module dds_wavegen #(
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smp_en,
    input  logic              sync_pulse,
    input  logic [ACC_W-1:0]  tuning_word,
    input  logic [IDX_W-1:0]  phase_ofs,
    input  logic [IDX_W-1:0]  duty,
    input  logic [IDX_W-1:0]  rise_frac,
    input  logic [IDX_W-1:0]  fall_frac,
    input  logic [2:0]        shape_sel,
    input  logic [1:0]        xform_sel,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_waddr,
    input  logic [DATA_W-1:0] tbl_wdata,
    output logic [DATA_W-1:0] sample_out,
    output logic              sample_vld
);
    import dds_pkg::*;

    logic [ACC_W-1:0]  acc_q;
    logic [IDX_W-1:0]  idx_q;
    logic              stg_vld;
    logic [DATA_W-1:0] tbl_rd;
    logic [DATA_W-1:0] shape_v;

    dds_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_en(smp_en),
        .sync_pulse(sync_pulse), .tw(tuning_word), .ofs(phase_ofs),
        .mirror(xform_sel[XF_MIRROR_BIT]),
        .acc_q(acc_q), .idx_q(idx_q), .stg_vld(stg_vld)
    );

    dds_sample_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_tbl (
        .clk(clk), .en(en), .we(tbl_we), .waddr(tbl_waddr),
        .wdata(tbl_wdata), .raddr(idx_q), .rdata(tbl_rd)
    );

    dds_shape_calc #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_shape (
        .idx(idx_q), .shape(shape_sel), .duty(duty), .rise(rise_frac),
        .fall(fall_frac), .tbl_data(tbl_rd), .value(shape_v)
    );

    // Output register with per-period inversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= stg_vld;
            if (stg_vld)
                sample_out <= xform_sel[XF_INVERT_BIT] ? ~shape_v : shape_v;
        end
    end
endmodule

// File: rtl/dds_wavegen_chk.sv
// Assertion checker for dds_wavegen, bound to every instance of the top.
module dds_wavegen_chk #(
    parameter int ACC_W  = 32,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              smp_en,
    input logic              sync_pulse,
    input logic [ACC_W-1:0]  tuning_word,
    input logic [2:0]        shape_sel,
    input logic [1:0]        xform_sel,
    input logic [DATA_W-1:0] sample_out,
    input logic              sample_vld,
    input logic [ACC_W-1:0]  acc_q,
    input logic              stg_vld
);
    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && smp_en && !sync_pulse) |=> acc_q == $past(acc_q) + $past(tuning_word));

    // R2
    vld_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(smp_en && en, 2));

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample_out));

    // R3
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sync_pulse) |=> acc_q == ($past(smp_en) ? $past(tuning_word) : '0));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc_q == '0 && !stg_vld && !sample_vld));

    // R11
    midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && shape_sel > 3'd4 && !xform_sel[1]) |=> sample_out == (DATA_W'(1) << (DATA_W - 1)));
endmodule

bind dds_wavegen dds_wavegen_chk #(.ACC_W(ACC_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_en(smp_en),
    .sync_pulse(sync_pulse), .tuning_word(tuning_word),
    .shape_sel(shape_sel), .xform_sel(xform_sel),
    .sample_out(sample_out), .sample_vld(sample_vld),
    .acc_q(acc_q), .stg_vld(stg_vld)
);

// File: tb/dds_wavegen_tb.sv
// Self-checking bench: full-period sweeps of every shape and transform
// against an arithmetic model of the requirements.
module dds_wavegen_tb_top;
    localparam int CLK_P    = 10;
    localparam int MAX_CYC  = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, smp_en = 1'b0, sync_pulse = 1'b0;
    logic [31:0] tuning_word = '0;
    logic [11:0] phase_ofs = '0, duty = '0, rise_frac = '0, fall_frac = '0;
    logic [2:0]  shape_sel = '0;
    logic [1:0]  xform_sel = '0;
    logic        tbl_we = 1'b0;
    logic [11:0] tbl_waddr = '0;
    logic [15:0] tbl_wdata = '0;
    logic [15:0] sample_out;
    logic        sample_vld;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] m_acc = '0;
    logic [15:0] tbl_m [4096];

    always #(CLK_P/2) clk = ~clk;

    dds_wavegen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_en(smp_en),
        .sync_pulse(sync_pulse), .tuning_word(tuning_word),
        .phase_ofs(phase_ofs), .duty(duty), .rise_frac(rise_frac),
        .fall_frac(fall_frac), .shape_sel(shape_sel), .xform_sel(xform_sel),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .sample_out(sample_out), .sample_vld(sample_vld)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    function automatic int pulse_m(input int p, input int d, input int r, input int f);
        if (p < r)              return p * 65535 / r;
        else if (p < r + d)     return 65535;
        else if (p < r + d + f) return 65535 - ((p - r - d) * 65535 / f);
        else                    return 0;
    endfunction

    function automatic int expect_m(input logic sync);
        int idx, v;
        idx = ((sync ? 0 : int'(m_acc[31:20])) + int'(phase_ofs)) % 4096;
        if (xform_sel[0]) idx = 4095 - idx;
        case (shape_sel)
            3'd0, 3'd1: v = int'(tbl_m[idx]);
            3'd2:       v = pulse_m(idx, int'(duty), int'(rise_frac), int'(fall_frac));
            3'd3:       v = pulse_m(idx, 0, 2048, 2048);
            3'd4:       v = idx * 16 + idx / 256;
            default:    v = 32768;
        endcase
        if (xform_sel[1]) v = 65535 - v;
        return v;
    endfunction

    // One sample: drive enable, wait two edges, compare at the falling edge
    task automatic do_sample(input string req, input logic sync);
        int e;
        e = expect_m(sync);
        smp_en = 1'b1;
        sync_pulse = sync;
        @(negedge clk);
        if (sync) m_acc = tuning_word;
        else      m_acc = m_acc + tuning_word;
        smp_en = 1'b0;
        sync_pulse = 1'b0;
        @(negedge clk);
        check({req, " vld"}, int'(sample_vld), 1);
        check(req, int'(sample_out), e);
    endtask

    task automatic sweep(input string req, input logic [2:0] shp, input logic [1:0] xf);
        shape_sel = shp;
        xform_sel = xf;
        tuning_word = 32'h0010_0000;
        do_sample(req, 1'b1);
        for (int k = 1; k < 4096; k++) do_sample(req, 1'b0);
    endtask

    task automatic tbl_write(input int a, input int v);
        tbl_we = 1'b1;
        tbl_waddr = 12'(a);
        tbl_wdata = 16'(v);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(sample_out), 0);
        check("R1", int'(sample_vld), 0);

        // Load table while disabled
        for (int i = 0; i < 4096; i++) begin
            tbl_m[i] = 16'((i * 40503 + 17) & 16'hFFFF);
            tbl_write(i, int'(tbl_m[i]));
        end
        en = 1'b1;
        m_acc = '0;
        @(negedge clk);

        // R4 table shapes with offset
        phase_ofs = 12'd7;
        sweep("R4 custom", 3'd1, 2'd0);
        phase_ofs = 12'd2049;
        sweep("R4 sine", 3'd0, 2'd0);
        // R9 mirror on table, invert and both on sawtooth
        phase_ofs = 12'd0;
        sweep("R9 mirror", 3'd1, 2'd1);
        // R8 sawtooth
        sweep("R8 saw", 3'd4, 2'd0);
        sweep("R9 invert", 3'd4, 2'd2);
        sweep("R9 both", 3'd4, 2'd3);
        // R6 trapezoid
        rise_frac = 12'd300; duty = 12'd1000; fall_frac = 12'd500;
        sweep("R6 trapezoid", 3'd2, 2'd0);
        // R6 square wave, duty one step
        rise_frac = 12'd0; duty = 12'd1; fall_frac = 12'd0;
        sweep("R6 square", 3'd2, 2'd0);
        // R7 triangle ignores pulse inputs
        rise_frac = 12'd17; duty = 12'd900; fall_frac = 12'd3000;
        sweep("R7 triangle", 3'd3, 2'd0);

        // R2 fine tuning, immediate change, wraparound
        shape_sel = 3'd4; xform_sel = 2'd0; phase_ofs = 12'd5;
        tuning_word = 32'h0123_4567;
        do_sample("R2", 1'b1);
        for (int k = 0; k < 20; k++) do_sample("R2", 1'b0);
        tuning_word = 32'h0000_0431;
        for (int k = 0; k < 10; k++) do_sample("R2", 1'b0);
        tuning_word = 32'hF000_0001;
        for (int k = 0; k < 30; k++) do_sample("R2", 1'b0);

        // R3 sync mid-stream restarts phase
        tuning_word = 32'h0A00_0000;
        for (int k = 0; k < 3; k++) do_sample("R3", 1'b0);
        do_sample("R3", 1'b1);
        do_sample("R3", 1'b0);
        // R3 sync without sample enable clears accumulator
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        m_acc = '0;
        @(negedge clk);
        do_sample("R3", 1'b0);

        // R11 undefined shape codes give midscale
        shape_sel = 3'd6;
        do_sample("R11", 1'b0);
        shape_sel = 3'd7; xform_sel = 2'd2;
        do_sample("R11", 1'b0);
        xform_sel = 2'd0;

        // R5 write while enabled is ignored
        shape_sel = 3'd1; phase_ofs = 12'd100;
        tbl_write(100, int'(~tbl_m[100]));
        do_sample("R5 ignored", 1'b1);
        // R5 write while disabled is taken
        en = 1'b0;
        @(negedge clk);
        tbl_m[100] = 16'h5A5A;
        tbl_write(100, 16'h5A5A);
        en = 1'b1;
        m_acc = '0;
        do_sample("R5 accepted", 1'b1);

        // R10 disabled: no samples, accumulator restarts at zero
        tuning_word = 32'h0330_0000;
        do_sample("R10", 1'b0);
        en = 1'b0;
        smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0;
        @(negedge clk);
        check("R10 no vld", int'(sample_vld), 0);
        @(negedge clk);
        check("R10 no vld", int'(sample_vld), 0);
        en = 1'b1;
        m_acc = '0;
        do_sample("R10 restart", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule